// File: doc/BRIEF.md
# I2C Target Byte Memory

This block is a two-wire serial target that gives a bus master byte access to an on-chip 8192-entry, 8-bit memory. It runs from a system clock at least ten times faster than the serial clock. It brings the clock and data lines through a short synchronizer and detects START, repeated START and STOP conditions on the synchronized levels. The data line is open-drain: the block never drives it high and only raises a pull-low enable.

A transaction opens with an address word. Its four type bits and its three strap bits must match, and its last bit selects the direction. A write transaction carries two address bytes, high byte first, followed by any number of data bytes. Each data byte is stored at once and the address then advances. The address is 13 bits wide, wraps from the top of the array to zero, and is kept between transactions. A read then returns data from where the last access stopped, or from a freshly loaded address when the write-mode address bytes come before a repeated START. A write-protect input keeps the array unchanged while the handshake goes on as usual.

Top module: `i2c_mem_target`

## Requirements
- R1: The address word is taken MSB first. The block acknowledges it only when bits 7..4 are 1010 and bits 3..1 equal strap_i[2], strap_i[1], strap_i[0]. Bit 0 selects write (0) or read (1). On a mismatch the block does not acknowledge, returns to idle, and ignores every later byte until the next START.
- R2: In write mode the first two bytes after the address word form the memory address, high byte first. Only the low 13 bits are used, so the top three bits of the high byte have no effect. Each following data byte is written to the current address. Every received byte that is accepted is acknowledged by a low level on the data line during the 9th clock.
- R3: After each data byte is stored, the address advances by one. It wraps from 0x1FFF to 0x0000, so a long burst overwrites from the start of the array.
- R4: While wprot_i is high, data bytes are still acknowledged, but no array location changes.
- R5: A random read sends the write-mode address word and two address bytes, then a repeated START and the read-mode address word. It returns the byte stored at the loaded address.
- R6: In read mode the block sends 8 bits MSB first. When the master acknowledges the 9th bit, it sends the next byte in sequence, wrapping from 0x1FFF to 0x0000.
- R7: When the master does not acknowledge a read byte, the block releases the data line and keeps it released until the next START or STOP.
- R8: A read with no address phase returns the byte after the last one accessed. After reset the address is 0x0000.
- R9: A START or STOP that arrives before the 8th bit of a byte has been taken aborts that byte and writes nothing. A START begins a new address word, and the loaded address is kept.
- R10: The pull-low enable is low after reset, is registered, and changes only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| strap_i | input | 3 | Address strap code, compared with address-word bits 3..1 |
| wprot_i | input | 1 | High blocks all array writes |
| sda_pull_o | output | 1 | High pulls the data line low |

## Verification
Two actions can share a cycle. The array write of a just-acknowledged data byte lands in the same cycle as the read-ahead port moving to the next address, so the byte the next read returns is formed while the write is still in progress. The bench provokes this with a current-address read straight after a page write, and with a page write across the 0x1FFF wrap followed by a sequential read. It judges both by comparing every returned byte with values the bench itself wrote. A second overlap is a START that lands in the middle of a data byte while an address is loaded. This case is judged by reading that location back after the repeated START and after a STOP, and finding it unchanged.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

  localparam int BYTE_W = 8;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_AHI,
    ST_AHI_ACK,
    ST_ALO,
    ST_ALO_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_WAIT
  } fsm_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_q;
  logic              sda_q;
  logic              scl_s;
  logic              sda_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign sda_lvl   = sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/i2c_mem_fsm.sv
module i2c_mem_fsm
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [2:0]        strap,
  input  logic              wprot,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [7:0]        wdata_o,
  output logic              sda_pull_o,
  output fsm_state_t        state_o
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam int HI_W  = ADDR_W - BYTE_W;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  fsm_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [7:0]        rx;
  logic [7:0]        tx;
  logic              rw_q;
  logic              mack_q;
  logic [HI_W-1:0]   hi_q;
  logic [ADDR_W-1:0] addr_q;
  logic              drive_q;
  logic              we_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [7:0]        wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      rx      <= '0;
      tx      <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      hi_q    <= '0;
      addr_q  <= '0;
      drive_q <= 1'b0;
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      we_q <= 1'b0;
      if (start_det) begin
        state   <= ST_DEV;
        cnt     <= '0;
        drive_q <= 1'b0;
      end else if (stop_det) begin
        state   <= ST_IDLE;
        drive_q <= 1'b0;
      end else begin
        case (state)
          ST_DEV, ST_AHI, ST_ALO, ST_WR: begin
            if (scl_rise && cnt != FULL) begin
              rx  <= {rx[6:0], sda_lvl};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              cnt <= '0;
              case (state)
                ST_DEV: begin
                  if (rx[7:1] == {DEV_TYPE, strap}) begin
                    rw_q    <= rx[0];
                    drive_q <= 1'b1;
                    state   <= ST_DEV_ACK;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                ST_AHI: begin
                  hi_q    <= rx[HI_W-1:0];
                  drive_q <= 1'b1;
                  state   <= ST_AHI_ACK;
                end
                ST_ALO: begin
                  addr_q  <= {hi_q, rx};
                  drive_q <= 1'b1;
                  state   <= ST_ALO_ACK;
                end
                default: begin
                  we_q    <= ~wprot;
                  waddr_q <= addr_q;
                  wdata_q <= rx;
                  addr_q  <= addr_q + 1'b1;
                  drive_q <= 1'b1;
                  state   <= ST_WR_ACK;
                end
              endcase
            end
          end
          ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WR_ACK: begin
            if (scl_fall) begin
              drive_q <= 1'b0;
              case (state)
                ST_DEV_ACK: begin
                  if (rw_q) begin
                    tx      <= rd_data;
                    drive_q <= ~rd_data[7];
                    addr_q  <= addr_q + 1'b1;
                    state   <= ST_RD;
                  end else begin
                    state <= ST_AHI;
                  end
                end
                ST_AHI_ACK: state <= ST_ALO;
                default:    state <= ST_WR;
              endcase
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (cnt == LAST) begin
                drive_q <= 1'b0;
                cnt     <= '0;
                state   <= ST_RD_ACK;
              end else begin
                tx      <= {tx[6:0], 1'b0};
                drive_q <= ~tx[6];
                cnt     <= cnt + 1'b1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_lvl;
            end else if (scl_fall) begin
              if (mack_q) begin
                tx      <= rd_data;
                drive_q <= ~rd_data[7];
                addr_q  <= addr_q + 1'b1;
                state   <= ST_RD;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          default: begin
          end
        endcase
      end
    end
  end

  assign addr_o     = addr_q;
  assign we_o       = we_q;
  assign waddr_o    = waddr_q;
  assign wdata_o    = wdata_q;
  assign sda_pull_o = drive_q;
  assign state_o    = state;

endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wprot_i,
  output logic       sda_pull_o
);

  logic              sda_lvl;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic [7:0]        rd_data;
  logic [ADDR_W-1:0] cur_addr;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [7:0]        mem_wdata;
  fsm_state_t        fsm_state;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_mem_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .sda_lvl    (sda_lvl),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .strap      (strap_i),
    .wprot      (wprot_i),
    .rd_data    (rd_data),
    .addr_o     (cur_addr),
    .we_o       (mem_we),
    .waddr_o    (mem_waddr),
    .wdata_o    (mem_wdata),
    .sda_pull_o (sda_pull_o),
    .state_o    (fsm_state)
  );

  i2c_mem_array #(.ADDR_W(ADDR_W)) u_array (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (cur_addr),
    .rdata (rd_data)
  );

endmodule

// File: rtl/i2c_mem_chk.sv
module i2c_mem_chk
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              wprot_i,
  input logic              sda_pull_o,
  input fsm_state_t        fsm_state,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              mem_we
);

  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull_o) |-> !scl_i); // R10

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (fsm_state == ST_IDLE) |-> !sda_pull_o); // R1

  AST_WAIT_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (fsm_state == ST_WAIT) |-> !sda_pull_o); // R7

  AST_WP_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    (wprot_i && $past(wprot_i)) |-> !mem_we); // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$stable(cur_addr) && $past(fsm_state) != ST_ALO)
      |-> (cur_addr == ADDR_W'($past(cur_addr) + 1'b1))); // R3

  AST_WE_IN_ACK: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (fsm_state == ST_WR_ACK)); // R2

endmodule

bind i2c_mem_target i2c_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .scl_i      (scl_i),
  .wprot_i    (wprot_i),
  .sda_pull_o (sda_pull_o),
  .fsm_state  (fsm_state),
  .cur_addr   (cur_addr),
  .mem_we     (mem_we)
);

// File: tb/test_i2c_mem_target.sv
module test_i2c_mem_target;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic       wprot = 1'b0;
  logic       sda_pull;
  wire        sda_bus = sda_m & ~sda_pull;

  int checks = 0;
  int errors = 0;

  localparam logic [7:0] DEVW = 8'hAA;
  localparam logic [7:0] DEVR = 8'hAB;

  always #10 clk = ~clk;

  i2c_mem_target i_i2c_mem_target (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl),
    .sda_i      (sda_bus),
    .strap_i    (strap),
    .wprot_i    (wprot),
    .sda_pull_o (sda_pull)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic quarter();
    repeat (5) @(negedge clk);
  endtask

  task automatic clock_bit(input logic b, output logic s);
    sda_m = b;
    quarter();
    scl = 1'b1;
    quarter();
    s = sda_bus;
    quarter();
    scl = 1'b0;
    quarter();
  endtask

  task automatic bus_start();
    sda_m = 1'b1;
    quarter();
    scl = 1'b1;
    quarter();
    sda_m = 1'b0;
    quarter();
    scl = 1'b0;
    quarter();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0;
    quarter();
    scl = 1'b1;
    quarter();
    sda_m = 1'b1;
    quarter();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
    clock_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, s);
      d[i] = s;
    end
    clock_bit(~mack, s);
  endtask

  task automatic send_ack(input string tag, input logic [7:0] b);
    logic ack;
    send_byte(b, ack);
    check(tag, int'(ack), 1);
  endtask

  task automatic begin_addr(input logic [15:0] a);
    bus_start();
    send_ack("R1 write address word acknowledged", DEVW);
    send_ack("R2 high address byte acknowledged", a[15:8]);
    send_ack("R2 low address byte acknowledged", a[7:0]);
  endtask

  task automatic begin_read();
    bus_start();
    send_ack("R1 read address word acknowledged", DEVR);
  endtask

  task automatic read_one_at(input logic [15:0] a, output logic [7:0] d);
    begin_addr(a);
    begin_read();
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  task automatic t_reset();
    check("R10 pull released after reset", int'(sda_pull), 0);
  endtask

  task automatic t_mismatch();
    logic ack;
    bus_start();
    send_byte(8'hBA, ack);
    check("R1 wrong type nibble not acknowledged", int'(ack), 0);
    send_byte(8'h00, ack);
    check("R1 later byte ignored after mismatch", int'(ack), 0);
    bus_stop();
    bus_start();
    send_byte(8'hA6, ack);
    check("R1 wrong strap code not acknowledged", int'(ack), 0);
    bus_stop();
  endtask

  task automatic t_byte_write();
    logic [7:0] d;
    begin_addr(16'hE123);
    send_ack("R2 data byte acknowledged", 8'h3C);
    bus_stop();
    read_one_at(16'h0123, d);
    check("R5 R2 random read of written byte, top bits ignored", int'(d), 8'h3C);
  endtask

  task automatic t_wrap();
    logic [7:0] d;
    begin_addr(16'h1FFE);
    send_ack("R2 page byte 0 acknowledged", 8'h11);
    send_ack("R2 page byte 1 acknowledged", 8'h22);
    send_ack("R3 byte after wrap acknowledged", 8'h33);
    bus_stop();
    begin_addr(16'h1FFE);
    begin_read();
    recv_byte(1'b1, d);
    check("R6 sequential byte at 0x1FFE", int'(d), 8'h11);
    recv_byte(1'b1, d);
    check("R6 sequential byte at 0x1FFF", int'(d), 8'h22);
    recv_byte(1'b0, d);
    check("R3 R6 wrapped byte at 0x0000", int'(d), 8'h33);
    bus_stop();
  endtask

  task automatic t_current_and_nack();
    logic [7:0] d;
    logic [8:0] tail;
    logic s;
    begin_addr(16'h0042);
    send_ack("R2 data byte acknowledged", 8'hE7);
    bus_stop();
    begin_addr(16'h0040);
    send_ack("R2 page byte acknowledged", 8'hA5);
    send_ack("R2 page byte acknowledged", 8'h5A);
    bus_stop();
    begin_read();
    recv_byte(1'b0, d);
    check("R8 current read after page write", int'(d), 8'hE7);
    bus_stop();
    begin_addr(16'h0040);
    begin_read();
    recv_byte(1'b0, d);
    check("R5 random read at 0x0040", int'(d), 8'hA5);
    for (int i = 8; i >= 0; i--) begin
      clock_bit(1'b1, s);
      tail[i] = s;
    end
    check("R7 line released after master NACK", int'(tail), 9'h1FF);
    bus_stop();
    begin_read();
    recv_byte(1'b0, d);
    check("R8 current read after random read", int'(d), 8'h5A);
    bus_stop();
  endtask

  task automatic t_wprot();
    logic [7:0] d;
    wprot = 1'b1;
    begin_addr(16'h0040);
    send_ack("R4 protected data byte still acknowledged", 8'h77);
    bus_stop();
    begin_read();
    recv_byte(1'b0, d);
    bus_stop();
    read_one_at(16'h0040, d);
    check("R4 read allowed, location unchanged", int'(d), 8'hA5);
    wprot = 1'b0;
  endtask

  task automatic t_abort();
    logic [7:0] d;
    logic s;
    begin_addr(16'h0100);
    send_ack("R2 data byte acknowledged", 8'hC3);
    bus_stop();
    begin_addr(16'h0100);
    for (int i = 0; i < 4; i++) clock_bit(1'b0, s);
    begin_read();
    recv_byte(1'b0, d);
    check("R9 repeated START mid-byte aborts, address kept", int'(d), 8'hC3);
    bus_stop();
    begin_addr(16'h0100);
    for (int i = 0; i < 4; i++) clock_bit(1'b1, s);
    bus_stop();
    read_one_at(16'h0100, d);
    check("R9 STOP mid-byte writes nothing", int'(d), 8'hC3);
  endtask

  task automatic t_reset_addr();
    logic [7:0] d;
    @(negedge clk);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 pull released after second reset", int'(sda_pull), 0);
    begin_read();
    recv_byte(1'b0, d);
    check("R8 current read after reset starts at 0x0000", int'(d), 8'h33);
    bus_stop();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_mismatch();
    t_byte_write();
    t_wrap();
    t_current_and_nack();
    t_wprot();
    t_abort();
    t_reset_addr();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule